// File: doc/BRIEF.md
# Partitioned SIMD integer multiplier

This block multiplies two 64-bit operands as packed integer vectors. The word is split into a lower and an upper 32-bit half. Each half has its own operation code and element width, so one cycle can run, for example, four signed 8-bit high-half multiplies in the lower half and one unsigned 32-bit low-product multiply in the upper half. When the lower half selects 64-bit elements, the two halves join into one 64-bit lane and the lower half's control governs the whole word.

Each lane gives a result as wide as the lane: either the low half or the high half of the full double-width product. The high half can treat the operands as signed×signed, unsigned×unsigned, or signed first operand × unsigned second operand. Lanes never exchange carries or partial products. The unit is a fixed two-stage pipeline. A request marked by `in_valid` comes out two clock edges later, with `out_valid` set.

Top module: `simd_imul`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after the edge that samples `in_valid` high, and stays low two edges after an edge that samples `in_valid` low. Back-to-back requests are accepted every cycle.
- R2: Operation codes per half: 0 = low W bits of the 2W-bit product, 1 = high W bits with both operands signed, 2 = high W bits with both unsigned, 3 = high W bits with the first operand (`in_a`) signed and the second (`in_b`) unsigned.
- R3: Element width codes per half: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Lane i of a half occupies bits [i*W +: W] of that half, and uses the same bits of `in_a` and `in_b`.
- R4: The lower half (bits 31:0) is governed only by `lo_op`/`lo_width`, and the upper half (bits 63:32) only by `hi_op`/`hi_width`, whenever `lo_width` is not 3.
- R5: `lo_width` = 3 selects one 64-bit lane over the whole word, governed by `lo_op`. `hi_op` and `hi_width` then have no effect on the result.
- R6: `hi_width` = 3 while `lo_width` is not 3 makes the upper half act as a single 32-bit lane.
- R7: No lane's result depends on operand bits outside that lane. Carries are cut at every element boundary, including for most-negative and all-ones values.
- R8: `out_result` keeps its last value in every cycle in which no new result is delivered.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_a | input | 64 | First operand vector (signed side for code 3) |
| in_b | input | 64 | Second operand vector |
| lo_op | input | 2 | Operation code for bits 31:0 (or the whole word in 64-bit mode) |
| lo_width | input | 2 | Element width code for bits 31:0; 3 fuses the word |
| hi_op | input | 2 | Operation code for bits 63:32 |
| hi_width | input | 2 | Element width code for bits 63:32; 3 acts as 32 |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Packed lane results |

## Verification
The latency properties assume that `in_valid` is a clean 0/1 level once reset is released, and that reset is not reasserted in mid-stream. The bench keeps to this by driving every input at the falling edge, holding reset only at the start, and randomising the valid bubbles only after release. The lane properties for zero and unit operands hold for any operand, so the bench covers them with corner patterns. It sweeps every operation and width code of both halves, including the fused code, over pairs of most-negative, all-ones, zero and near-maximum operands, and then over random operands with gaps between requests.

// File: rtl/simd_imul_pkg.sv
package simd_imul_pkg;

  typedef enum logic [1:0] {
    OP_MUL     = 2'd0,
    OP_MULH_SS = 2'd1,
    OP_MULH_UU = 2'd2,
    OP_MULH_SU = 2'd3
  } mul_op_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_w_e;

  typedef struct packed {
    mul_op_e op;
    elem_w_e ew;
  } half_ctrl_t;

endpackage

// File: rtl/imul_lane.sv
module imul_lane
  import simd_imul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  mul_op_e      op_i,
  output logic [W-1:0] res_o
);

  localparam int XW = W + 1;
  localparam int PW = 2 * XW;

  logic              a_signed;
  logic              b_signed;
  logic [XW-1:0]     a_x;
  logic [XW-1:0]     b_x;
  logic signed [PW-1:0] prod;
  logic [PW-2*W-1:0] prod_top_unused;

  // one extra bit per operand lets a single signed multiplier cover all
  // signed/unsigned pairings
  always_comb begin
    a_signed = (op_i == OP_MULH_SS) || (op_i == OP_MULH_SU);
    b_signed = (op_i == OP_MULH_SS);
    a_x      = {a_signed & a_i[W-1], a_i};
    b_x      = {b_signed & b_i[W-1], b_i};
    prod     = $signed({{XW{a_x[XW-1]}}, a_x}) * $signed({{XW{b_x[XW-1]}}, b_x});
    res_o    = (op_i == OP_MUL) ? prod[W-1:0] : prod[2*W-1:W];
  end

  assign prod_top_unused = prod[PW-1:2*W];

  // R2: a zero factor gives zero in every operation
  always_comb begin
    assert_zero_factor_R2: assert ((a_i != '0 && b_i != '0) || res_o == '0);
  end

  // R2: low product by one returns the first operand unchanged
  always_comb begin
    assert_unit_factor_R2: assert (op_i != OP_MUL || b_i != W'(1) || res_o == a_i);
  end

endmodule

// File: rtl/imul_half.sv
module imul_half
  import simd_imul_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int MIN_W  = 8
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  mul_op_e           op_i,
  input  elem_w_e           ew_i,
  output logic [HALF_W-1:0] res_o
);

  localparam int NSZ = $clog2(HALF_W / MIN_W) + 1;

  logic [HALF_W-1:0] cand [NSZ];

  // one bank of independent lanes per element size; no carry crosses a lane
  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int LW = MIN_W << k;
    localparam int NL = HALF_W / LW;
    logic [HALF_W-1:0] part;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      imul_lane #(.W(LW)) u_lane (
        .a_i  (a_i[l*LW +: LW]),
        .b_i  (b_i[l*LW +: LW]),
        .op_i (op_i),
        .res_o(part[l*LW +: LW])
      );
    end
    assign cand[k] = part;
  end

  // codes beyond the largest in-half size fall back to a full-half lane
  always_comb begin
    res_o = cand[NSZ-1];
    for (int k = 0; k < NSZ; k++) begin
      if (int'(ew_i) == k) res_o = cand[k];
    end
  end

endmodule

// File: rtl/simd_imul.sv
module simd_imul
  import simd_imul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        lo_op,
  input  logic [1:0]        lo_width,
  input  logic [1:0]        hi_op,
  input  logic [1:0]        hi_width,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  localparam int HALF_W = DATA_W / 2;

  // stage 1: operand and control capture
  logic              s1_en;
  logic              s1_valid_d, s1_valid_q;
  logic [DATA_W-1:0] s1_a_d, s1_a_q;
  logic [DATA_W-1:0] s1_b_d, s1_b_q;
  half_ctrl_t        s1_lo_d, s1_lo_q;
  half_ctrl_t        s1_hi_d, s1_hi_q;

  // stage 2: result register
  logic              s2_en;
  logic              s2_valid_d, s2_valid_q;
  logic [DATA_W-1:0] s2_res_d, s2_res_q;

  logic [DATA_W-1:0] full_res;
  logic [HALF_W-1:0] lo_res;
  logic [HALF_W-1:0] hi_res;
  logic              fused;
  logic [DATA_W-1:0] packed_res;

  imul_lane #(.W(DATA_W)) u_full (
    .a_i  (s1_a_q),
    .b_i  (s1_b_q),
    .op_i (s1_lo_q.op),
    .res_o(full_res)
  );

  imul_half #(.HALF_W(HALF_W), .MIN_W(MIN_W)) u_lo (
    .a_i  (s1_a_q[HALF_W-1:0]),
    .b_i  (s1_b_q[HALF_W-1:0]),
    .op_i (s1_lo_q.op),
    .ew_i (s1_lo_q.ew),
    .res_o(lo_res)
  );

  imul_half #(.HALF_W(HALF_W), .MIN_W(MIN_W)) u_hi (
    .a_i  (s1_a_q[DATA_W-1:HALF_W]),
    .b_i  (s1_b_q[DATA_W-1:HALF_W]),
    .op_i (s1_hi_q.op),
    .ew_i (s1_hi_q.ew),
    .res_o(hi_res)
  );

  always_comb begin
    fused      = (s1_lo_q.ew == EW_64);
    packed_res = fused ? full_res : {hi_res, lo_res};
  end

  // next-state logic
  always_comb begin
    s1_en      = in_valid;
    s1_valid_d = in_valid;
    s1_a_d     = s1_en ? in_a : s1_a_q;
    s1_b_d     = s1_en ? in_b : s1_b_q;
    s1_lo_d    = s1_en ? half_ctrl_t'({lo_op, lo_width}) : s1_lo_q;
    s1_hi_d    = s1_en ? half_ctrl_t'({hi_op, hi_width}) : s1_hi_q;
    s2_en      = s1_valid_q;
    s2_valid_d = s1_valid_q;
    s2_res_d   = s2_en ? packed_res : s2_res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
      s1_lo_q    <= '0;
      s1_hi_q    <= '0;
      s2_valid_q <= 1'b0;
      s2_res_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_a_q     <= s1_a_d;
      s1_b_q     <= s1_b_d;
      s1_lo_q    <= s1_lo_d;
      s1_hi_q    <= s1_hi_d;
      s2_valid_q <= s2_valid_d;
      s2_res_q   <= s2_res_d;
    end
  end

  assign out_valid  = s2_valid_q;
  assign out_result = s2_res_q;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

  always_comb begin
    assert_reset_idle_R9: assert (rst_n || (!out_valid && out_result == '0));
  end

endmodule

// File: tb/simd_imul_bench.sv
module simd_imul_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_a, in_b;
  logic [1:0]  lo_op, lo_width, hi_op, hi_width;
  logic        out_valid;
  logic [63:0] out_result;

  int total = 0;
  int bad   = 0;

  logic [63:0] exp_q [$];
  string       tag_q [$];
  bit          vd1 = 1'b0;
  bit          vd2 = 1'b0;

  always #5 clk = ~clk;

  simd_imul u_simd_imul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .lo_op(lo_op), .lo_width(lo_width), .hi_op(hi_op), .hi_width(hi_width),
    .out_valid(out_valid), .out_result(out_result)
  );

  // reference for one lane of width w, computed on wide unsigned arithmetic
  function automatic logic [63:0] lane_ref(input logic [63:0] a, input logic [63:0] b,
                                           input int w, input logic [1:0] op);
    logic [129:0] mask, ae, be, p;
    bit sa, sb;
    mask = (130'd1 << w) - 130'd1;
    sa = (op == 2'd1) || (op == 2'd3);
    sb = (op == 2'd1);
    ae = {66'd0, a} & mask;
    be = {66'd0, b} & mask;
    if (sa && a[w-1]) ae = ae | ~mask;
    if (sb && b[w-1]) be = be | ~mask;
    p = ae * be;
    if (op == 2'd0) return 64'(p & mask);
    return 64'((p >> w) & mask);
  endfunction

  function automatic logic [31:0] half_ref(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] op, input logic [1:0] wc);
    logic [31:0] r;
    int w;
    w = (wc == 2'd3) ? 32 : (8 << wc);
    r = '0;
    for (int i = 0; i < 32 / w; i++) begin
      r = r | 32'(lane_ref(64'(a >> (i * w)), 64'(b >> (i * w)), w, op) << (i * w));
    end
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] lop, input logic [1:0] lw,
                                        input logic [1:0] hop, input logic [1:0] hw);
    if (lw == 2'd3) return lane_ref(a, b, 64, lop);
    return {half_ref(a[63:32], b[63:32], hop, hw), half_ref(a[31:0], b[31:0], lop, lw)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check outputs at the falling edge, then drive the next request
  task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] lop, input logic [1:0] lw,
                      input logic [1:0] hop, input logic [1:0] hw);
    logic [63:0] e;
    string t;
    @(negedge clk);
    check(out_valid == vd2, "R1 valid timing", 64'(out_valid), 64'(vd2));
    if (out_valid && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(out_result == e, t, out_result, e);
    end
    in_valid = v; in_a = a; in_b = b;
    lo_op = lop; lo_width = lw; hi_op = hop; hi_width = hw;
    vd2 = vd1;
    vd1 = v;
    if (v) begin
      exp_q.push_back(model(a, b, lop, lw, hop, hw));
      if (lw == 2'd3)      t = "R5 fused lane";
      else if (hw == 2'd3) t = "R6 upper code 3";
      else                 t = "R2 R3 R4 R7 lanes";
      tag_q.push_back(t);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] pat [6];
    logic [63:0] held;
    pat[0] = 64'h0000_0000_0000_0000;
    pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pat[2] = 64'h8080_8080_8080_8080;
    pat[3] = 64'h8000_8000_8000_8000;
    pat[4] = 64'h7FFF_FFFF_7FFF_FFFF;
    pat[5] = 64'h8000_0000_0000_0001;

    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    lo_op = '0; lo_width = '0; hi_op = '0; hi_width = '0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
      check(out_result == '0, "R9 reset result", out_result, 64'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // sweep every control combination of both halves over corner pairs
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          step(1'b1, pat[i], pat[j], 2'(c), 2'(c >> 2), 2'(c >> 4), 2'(c >> 6));
        end
      end
    end

    // random operands, random control, random bubbles
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[9:8] != 2'd0, {$urandom, $urandom}, {$urandom, $urandom},
           r[1:0], r[3:2], r[5:4], r[7:6]);
    end

    // drain, then R8: result stays put without new requests
    repeat (3) step(1'b0, '0, '0, 2'd0, 2'd0, 2'd0, 2'd0);
    check(exp_q.size() == 0, "R1 all results delivered", 64'(exp_q.size()), 64'd0);
    held = out_result;
    repeat (4) begin
      step(1'b0, pat[1], pat[1], 2'd1, 2'd3, 2'd2, 2'd0);
      check(out_result == held, "R8 hold", out_result, held);
    end

    finish_run();
  end

endmodule